// File: doc/BRIEF.md
# Runahead Mode Controller

This block decides when an in-order pipeline model switches into a speculative prefetch mode and when it switches back. The instruction bus always carries the oldest instruction in the machine. When that instruction is a load that takes a long-latency miss, the block copies the architectural register file into a shadow copy. It records the load's program counter and raises its mode output. Later instructions then keep flowing.

While the mode is active, every register has a poison flag. An instruction that reads a poisoned register, or a load that misses again, poisons its destination and is flagged as dropped. A load whose address register is clean produces one prefetch request carrying that register's value. Register writes from the execution datapath still land in the working file during this time, but all of them are temporary.

When the data of the original miss returns, the block copies the shadow file back into the working file and clears every poison flag. It pulses a restore strobe and presents the saved program counter, so the pipeline can restart from the missing load.

Top module: `runahead_unit`

## Requirements
- R1: After reset, `runMode`, `pfValid` and `restoreStrobe` are 0 and every poison flag is clear.
- R2: A cycle with `instValid`, `instIsLoad` and `instMiss` all high while `runMode` is 0 sets `runMode` to 1 from the next cycle. `instMiss` on a non-load, or with `instValid` low, has no effect.
- R3: On entry, the shadow copy captures every register as it stands after that cycle's register write. `resumePc` takes `instPc` of the missing load from the next cycle.
- R4: While `runMode` is 1, a valid instruction is poisoned in either of two cases. The first is that source A, or source B when `instUseB` is 1, carries a poison flag. The second is that it is a missing load. For a poisoned instruction, `dropInst` is 1 in the same cycle and its destination becomes poisoned. A valid unpoisoned instruction with `instWritesDst` clears its destination's flag. The missing load that triggers entry poisons its own destination.
- R5: A load in runahead mode with an unpoisoned source A gives `pfValid` = 1 for exactly one cycle, in the next cycle. `pfAddr` equals the working value of source A. A poisoned address, or any load in normal mode, gives no prefetch.
- R6: `fillValid` while `runMode` is 1 sets `runMode` to 0 in the next cycle and pulses `restoreStrobe` for that one cycle. `resumePc` still holds the PC of the missing load that started the mode. Instructions presented in the fill cycle issue no prefetch.
- R7: After the restore, every register reads its shadow value, so no write made in runahead mode is visible. All poison flags are clear.
- R8: A miss during runahead mode neither leaves the mode nor replaces the shadow copy or `resumePc`. It poisons that load's destination.
- R9: `fillValid` while `runMode` is 0 changes nothing: no strobe, no mode change.
- R10: `rdData` shows the working value of register `rdAddr` in the same cycle, including writes made in runahead mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | Oldest instruction slot holds an instruction |
| instIsLoad | input | 1 | Instruction is a load (source A is its address) |
| instMiss | input | 1 | Load took a long-latency miss |
| instSrcA | input | IDX_W | First source register |
| instSrcB | input | IDX_W | Second source register |
| instUseB | input | 1 | Second source is read |
| instDst | input | IDX_W | Destination register |
| instWritesDst | input | 1 | Instruction writes a destination |
| instPc | input | PC_W | Instruction program counter |
| wrEn | input | 1 | Register write from the execution datapath |
| wrAddr | input | IDX_W | Register write index |
| wrData | input | DATA_W | Register write value |
| fillValid | input | 1 | Data for the outstanding miss returned |
| rdAddr | input | IDX_W | Read port index |
| runMode | output | 1 | Runahead mode active |
| dropInst | output | 1 | Current instruction is poisoned and dropped |
| pfValid | output | 1 | Prefetch request |
| pfAddr | output | DATA_W | Prefetch address |
| restoreStrobe | output | 1 | One-cycle restore pulse |
| resumePc | output | PC_W | PC to resume from |
| rdData | output | DATA_W | Working register value |

## Verification
The combinational outputs are due in the cycle the stimulus is presented. These are `dropInst` and `rdData`. Everything registered is due exactly one clock edge later: the mode change, the prefetch, the restore pulse and `resumePc`. The next cycle sees the effect of the restore on the registers and the poison flags.

The driver stamps each expected item with the cycle it is due, counted in rising edges. The monitor compares it in the falling half of that cycle. A registered result is therefore never sampled early, and a late one is reported as a mismatch. The sequence interleaves poison chains, clean and poisoned loads, a second miss and speculative writes, and then checks the registers after the restore.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef struct packed {
    logic takeCkpt;
    logic restore;
    logic pfIssue;
    logic runMode;
  } raStrobes_t;
endpackage

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
  import ra_pkg::*;
#(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic             instIsLoad,
  input  logic             instMiss,
  input  logic [IDX_W-1:0] instSrcA,
  input  logic [IDX_W-1:0] instSrcB,
  input  logic             instUseB,
  input  logic [IDX_W-1:0] instDst,
  input  logic             instWritesDst,
  input  logic             fillValid,
  output raStrobes_t       strobes,
  output logic             dropInst,
  output logic             pfValid,
  output logic             restoreStrobe
);
  logic                runMode;
  logic [NUM_REGS-1:0] invBits, invNext;
  logic                srcInv, isMissLoad, takeCkpt, restore, pfIssue;

  always_comb begin
    srcInv     = invBits[instSrcA] | (instUseB & invBits[instSrcB]);
    isMissLoad = instValid & instIsLoad & instMiss;
    takeCkpt   = !runMode & isMissLoad;
    restore    = runMode & fillValid;
    pfIssue    = runMode & !fillValid & instValid & instIsLoad & !invBits[instSrcA];
    dropInst   = runMode & instValid & (srcInv | isMissLoad);
  end

  // poison flag next state
  always_comb begin
    invNext = invBits;
    if (restore) begin
      invNext = '0;
    end else if (takeCkpt) begin
      invNext = '0;
      if (instWritesDst) invNext[instDst] = 1'b1;
    end else if (runMode && instValid && instWritesDst) begin
      invNext[instDst] = srcInv | isMissLoad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runMode       <= 1'b0;
      invBits       <= '0;
      pfValid       <= 1'b0;
      restoreStrobe <= 1'b0;
    end else begin
      invBits       <= invNext;
      pfValid       <= pfIssue;
      restoreStrobe <= restore;
      if (restore)       runMode <= 1'b0;
      else if (takeCkpt) runMode <= 1'b1;
    end
  end

  assign strobes = '{takeCkpt: takeCkpt, restore: restore, pfIssue: pfIssue, runMode: runMode};

  p_entry_needs_miss_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runMode) |-> $past(instValid && instIsLoad && instMiss));
  p_no_reenter_r8: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && instValid && instIsLoad && instMiss && !fillValid) |=> runMode);
  p_exit_on_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(runMode) |-> $past(fillValid));
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    restoreStrobe |=> !restoreStrobe);
  p_strobe_normal_r6: assert property (@(posedge clk) disable iff (!rstN)
    restoreStrobe |-> !runMode);
  p_pf_in_runahead_r5: assert property (@(posedge clk) disable iff (!rstN)
    pfValid |-> $past(runMode));
  p_inv_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    !runMode |-> (invBits == '0));
endmodule

// File: rtl/runahead_regs.sv
module runahead_regs
  import ra_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  raStrobes_t        strobes,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  instSrcA,
  input  logic [PC_W-1:0]   instPc,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] pfAddr,
  output logic [PC_W-1:0]   resumePc
);
  logic [DATA_W-1:0] workFile [NUM_REGS];
  logic [DATA_W-1:0] ckptFile [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wrEn && (wrAddr == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        workFile[i] <= '0;
        ckptFile[i] <= '0;
      end else begin
        if (strobes.restore) workFile[i] <= ckptFile[i];
        else if (hit)        workFile[i] <= wrData;
        if (strobes.takeCkpt) ckptFile[i] <= hit ? wrData : workFile[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfAddr   <= '0;
      resumePc <= '0;
    end else begin
      if (strobes.pfIssue)  pfAddr   <= workFile[instSrcA];
      if (strobes.takeCkpt) resumePc <= instPc;
    end
  end

  assign rdData = workFile[rdAddr];

  p_pc_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.runMode && $past(strobes.runMode)) |-> $stable(resumePc));
  p_excl_strobes_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.takeCkpt && strobes.restore));
endmodule

// File: rtl/runahead_unit.sv
module runahead_unit
  import ra_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 32,
  parameter int PC_W     = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic              instIsLoad,
  input  logic              instMiss,
  input  logic [IDX_W-1:0]  instSrcA,
  input  logic [IDX_W-1:0]  instSrcB,
  input  logic              instUseB,
  input  logic [IDX_W-1:0]  instDst,
  input  logic              instWritesDst,
  input  logic [PC_W-1:0]   instPc,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fillValid,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic              runMode,
  output logic              dropInst,
  output logic              pfValid,
  output logic [DATA_W-1:0] pfAddr,
  output logic              restoreStrobe,
  output logic [PC_W-1:0]   resumePc,
  output logic [DATA_W-1:0] rdData
);
  raStrobes_t strobes;

  runahead_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instIsLoad(instIsLoad),
    .instMiss(instMiss), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .instUseB(instUseB), .instDst(instDst), .instWritesDst(instWritesDst),
    .fillValid(fillValid), .strobes(strobes), .dropInst(dropInst),
    .pfValid(pfValid), .restoreStrobe(restoreStrobe)
  );

  runahead_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .PC_W(PC_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .instSrcA(instSrcA), .instPc(instPc), .rdAddr(rdAddr),
    .rdData(rdData), .pfAddr(pfAddr), .resumePc(resumePc)
  );

  assign runMode = strobes.runMode;
endmodule

// File: tb/tb_runahead_unit.sv
module tb_runahead_unit;
  localparam int IDX_W = 4;
  localparam int S_MODE = 0, S_PFV = 1, S_PFA = 2, S_RST = 3, S_PC = 4, S_DROP = 5, S_RD = 6;

  typedef struct {
    int          due;
    int          sig;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 0, rstN = 0;
  logic instValid, instIsLoad, instMiss, instUseB, instWritesDst, wrEn, fillValid;
  logic [IDX_W-1:0] instSrcA, instSrcB, instDst, wrAddr, rdAddr;
  logic [31:0] instPc, wrData;
  logic runMode, dropInst, pfValid, restoreStrobe;
  logic [31:0] pfAddr, resumePc, rdData;

  item_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  runahead_unit dut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] getSig(int s);
    case (s)
      S_MODE: return {31'b0, runMode};
      S_PFV:  return {31'b0, pfValid};
      S_PFA:  return pfAddr;
      S_RST:  return {31'b0, restoreStrobe};
      S_PC:   return resumePc;
      S_DROP: return {31'b0, dropInst};
      default: return rdData;
    endcase
  endfunction

  // monitor: compares due items in the low half of each cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = getSig(it.sig);
      checks++;
      if (it.due != cyc || act !== it.exp) begin
        fails++;
        $display("FAIL %s sig=%0d cycle=%0d actual=%h expected=%h", it.tag, it.sig, cyc, act, it.exp);
      end
    end
  end

  task automatic expect_at(int delay, int sig, logic [31:0] v, string tag);
    q.push_back('{due: cyc + delay, sig: sig, exp: v, tag: tag});
  endtask

  task automatic idle();
    instValid = 0; instIsLoad = 0; instMiss = 0; instUseB = 0; instWritesDst = 0;
    instSrcA = 0; instSrcB = 0; instDst = 0; instPc = 0;
    wrEn = 0; wrAddr = 0; wrData = 0; fillValid = 0; rdAddr = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic inst(logic ld, logic miss, int a, int b, logic useB, int d, logic wd, logic [31:0] pc);
    instValid = 1; instIsLoad = ld; instMiss = miss; instSrcA = IDX_W'(a); instSrcB = IDX_W'(b);
    instUseB = useB; instDst = IDX_W'(d); instWritesDst = wd; instPc = pc;
  endtask

  task automatic wr(int a, logic [31:0] v);
    wrEn = 1; wrAddr = IDX_W'(a); wrData = v;
  endtask

  task automatic rd(int a, logic [31:0] v, string tag);
    rdAddr = IDX_W'(a); expect_at(0, S_RD, v, tag);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1; rstN = 1;
    // R1 reset state
    expect_at(0, S_MODE, 0, "R1"); expect_at(0, S_PFV, 0, "R1"); expect_at(0, S_RST, 0, "R1");
    wr(1, 32'h100); tick();
    wr(2, 32'h200); tick();
    wr(3, 32'h300); tick();
    wr(4, 32'h5); tick();
    // R9 fill in normal mode ignored
    fillValid = 1; expect_at(1, S_RST, 0, "R9"); expect_at(1, S_MODE, 0, "R9"); tick();
    // R2 miss on non-load ignored
    inst(0, 1, 1, 0, 0, 6, 1, 32'h10); expect_at(1, S_MODE, 0, "R2"); tick();
    // R5 normal load no prefetch, miss flag without valid ignored
    inst(1, 0, 1, 0, 0, 6, 1, 32'h14); expect_at(1, S_PFV, 0, "R5"); tick();
    instMiss = 1; instIsLoad = 1; expect_at(1, S_MODE, 0, "R2"); tick();
    // entry: missing load pc 0x40, dst r5, with write r6 in same cycle
    inst(1, 1, 1, 0, 0, 5, 1, 32'h40); wr(6, 32'h66);
    expect_at(0, S_DROP, 0, "R4");
    expect_at(1, S_MODE, 1, "R2"); expect_at(1, S_PC, 32'h40, "R3");
    tick();
    // A: reads poisoned r5 -> r7, speculative write r2
    inst(0, 0, 5, 0, 0, 7, 1, 32'h44); wr(2, 32'hDEAD);
    expect_at(0, S_DROP, 1, "R4"); tick();
    // B: r7 (poisoned) + r2 -> r8
    inst(0, 0, 7, 2, 1, 8, 1, 32'h48); expect_at(0, S_DROP, 1, "R4"); tick();
    // C: r2 -> r7 clears poison; read sees speculative write
    inst(0, 0, 2, 0, 0, 7, 1, 32'h4C); expect_at(0, S_DROP, 0, "R4");
    rd(2, 32'hDEAD, "R10"); tick();
    // D: reads r7, now clean
    inst(0, 0, 7, 0, 0, 0, 0, 32'h50); expect_at(0, S_DROP, 0, "R4"); tick();
    // E: load clean r3 -> prefetch 0x300
    inst(1, 0, 3, 0, 0, 9, 1, 32'h54); expect_at(0, S_DROP, 0, "R4");
    expect_at(1, S_PFV, 1, "R5"); expect_at(1, S_PFA, 32'h300, "R5"); tick();
    // F: load poisoned address r8 -> no prefetch
    inst(1, 0, 8, 0, 0, 10, 1, 32'h58); expect_at(0, S_DROP, 1, "R4");
    expect_at(1, S_PFV, 0, "R5"); tick();
    // G: second miss, address r4 clean
    inst(1, 1, 4, 0, 0, 11, 1, 32'h80); expect_at(0, S_DROP, 1, "R8");
    expect_at(1, S_MODE, 1, "R8"); expect_at(1, S_PC, 32'h40, "R8");
    expect_at(1, S_PFV, 1, "R5"); expect_at(1, S_PFA, 32'h5, "R5"); tick();
    // H: consumer of second miss; speculative write r3
    inst(0, 0, 11, 0, 0, 12, 1, 32'h84); wr(3, 32'hBAD);
    expect_at(0, S_DROP, 1, "R8"); expect_at(1, S_PFV, 0, "R5"); tick();
    // I: fill with a clean load presented
    fillValid = 1; inst(1, 0, 1, 0, 0, 13, 1, 32'h88);
    expect_at(1, S_MODE, 0, "R6"); expect_at(1, S_RST, 1, "R6");
    expect_at(1, S_PC, 32'h40, "R6"); expect_at(1, S_PFV, 0, "R6"); tick();
    rd(2, 32'h200, "R7"); expect_at(1, S_RST, 0, "R6"); tick();
    rd(3, 32'h300, "R7"); tick();
    rd(6, 32'h66, "R3"); tick();
    rd(1, 32'h100, "R7"); tick();
    // second episode: poison flags start clear
    inst(1, 1, 1, 0, 0, 12, 1, 32'h90);
    expect_at(1, S_MODE, 1, "R2"); expect_at(1, S_PC, 32'h90, "R3"); tick();
    inst(0, 0, 5, 0, 0, 0, 0, 32'h94); expect_at(0, S_DROP, 0, "R7"); tick();
    inst(0, 0, 12, 0, 0, 0, 0, 32'h98); expect_at(0, S_DROP, 1, "R4"); tick();
    fillValid = 1; expect_at(1, S_MODE, 0, "R6"); expect_at(1, S_RST, 1, "R6"); tick();
    tick(); tick();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #200000; fails++; $display("FAIL watchdog expired"); end
    join_any
    if (q.size() > 0) begin
      fails++;
      $display("FAIL %0d expected items never compared", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule